// File: doc/BRIEF.md
# Stereo Gain Ramp with Mute Detection

This block scales a stereo stream of signed 16-bit samples by a shared gain coefficient. The coefficient never jumps. On every sample strobe it moves toward a goal by a fixed step. A full swing between unity and silence therefore takes 1024 strobes, and no click is heard when the level changes.

The goal is set by a 7-bit attenuation code that is loaded with a one-cycle pulse. A soft-mute request overrides the code and drives the goal to zero while it is held. A new code or a change of the mute request may arrive in the middle of a ramp. The ramp then turns toward the new goal from wherever the coefficient stands.

Each channel raises its own mute flag when the coefficient is zero. It also raises the flag when that channel's input has been zero for a long unbroken run. Downstream logic can use the flag to silence the analog stage.

Top module: `atten_ramp`

## Requirements
- R1: With code 0x7F settled, each output sample equals its input sample, including -32768 and 32767.
- R2: Code 0x00 sets the goal to zero. Once the coefficient has arrived there, every output sample is zero.
- R3: A code n in 0x01..0x7E sets the goal to n*512, where 65536 is unity. The output is input*coef/65536, rounded toward zero. The coefficient never exceeds 65536.
- R4: On each strobe the coefficient moves toward its goal by 64, or lands exactly on the goal if the goal is closer than that. It never overshoots and it does not change without a strobe. A swing from 65536 to 0 takes exactly 1024 strobes.
- R5: A code loaded in the middle of a ramp redirects the ramp from the current coefficient. A load takes effect at the first strobe after the load cycle. A strobe in the same cycle as the load still uses the previous code.
- R6: While mute_req is high, the goal is zero and the coefficient ramps down at the R4 rate. After release it ramps back to the loaded code's goal.
- R7: Both mute_l and mute_r are high whenever the coefficient is zero.
- R8: A channel's mute flag is high once that channel has seen 8192 or more consecutive zero input samples at strobes. The count saturates. A nonzero sample on that channel clears it, and the other channel's count is unaffected.
- R9: Reset is synchronous and active high. While it is applied, both outputs are zero, even when strobes arrive. Reset leaves the code at 0x7F, the coefficient at 65536 and both zero-run counts at 0, so both flags are low.
- R10: Outputs are registered at the strobe edge. They use the coefficient as it stood before that strobe's step, and they hold between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| in_l | input | 16 | Left input sample, two's complement |
| in_r | input | 16 | Right input sample, two's complement |
| att_code | input | 7 | Attenuation code |
| att_load | input | 1 | Loads att_code as the new goal |
| mute_req | input | 1 | Soft-mute request, level sensitive |
| out_l | output | 16 | Scaled left sample |
| out_r | output | 16 | Scaled right sample |
| mute_l | output | 1 | Left mute flag |
| mute_r | output | 1 | Right mute flag |

## Verification
The hardest situations to reach are the coefficient's exact position in the middle of a ramp and the exact strobe on which a zero run saturates.

The coefficient is not a port. The bench drives -32768 on the left channel throughout most phases, so out_l reads back minus half the coefficient without loss. An arithmetic model then tracks every step, including retargets, mute releases and a load that coincides with a strobe.

The zero-run threshold is reached with 8192 zero samples on one channel while the other stays nonzero. The flag is compared at every strobe around the boundary.

All 127 nonzero codes are swept in ascending order, which needs only short settling ramps between codes.

// File: rtl/atten_ramp_pkg.sv
package atten_ramp_pkg;

    // default geometry
    localparam int SMP_W       = 16;
    localparam int ATT_CODE_W  = 7;
    localparam int GAIN_FRAC_W = 16;
    localparam int RAMP_STEP   = 64;
    localparam int ZRUN_LOG2   = 13;

    // which way the coefficient heads on the next strobe
    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_e;

    // one slew decision: direction and the value reached
    typedef struct packed {
        slew_dir_e                dir;
        logic [GAIN_FRAC_W:0]     next;
    } slew_t;

endpackage

// File: rtl/gain_slew.sv
module gain_slew
    import atten_ramp_pkg::*;
#(
    parameter int CODE_W = ATT_CODE_W,
    parameter int FRAC_W = GAIN_FRAC_W,
    parameter int STEP   = RAMP_STEP,
    localparam int COEF_W = FRAC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [CODE_W-1:0] code_in,
    input  logic              code_ld,
    input  logic              mute_req,
    output logic [COEF_W-1:0] coef
);

    localparam logic [COEF_W-1:0] UNITY   = COEF_W'(1) << FRAC_W;
    localparam logic [COEF_W-1:0] STEP_V  = COEF_W'(STEP);
    localparam int                SHIFT   = FRAC_W - CODE_W;
    localparam logic [CODE_W-1:0] FULL    = '1;

    logic [CODE_W-1:0] code_q;
    logic [COEF_W-1:0] goal;
    slew_t             slew;

    function automatic logic [COEF_W-1:0] code_gain(input logic [CODE_W-1:0] c);
        if (c == FULL) return UNITY;
        return COEF_W'(c) << SHIFT;
    endfunction

    always_comb begin
        goal = mute_req ? '0 : code_gain(code_q);
        if (goal > coef) begin
            slew.dir  = SLEW_UP;
            slew.next = (goal - coef > STEP_V) ? coef + STEP_V : goal;
        end else if (goal < coef) begin
            slew.dir  = SLEW_DOWN;
            slew.next = (coef - goal > STEP_V) ? coef - STEP_V : goal;
        end else begin
            slew.dir  = SLEW_HOLD;
            slew.next = coef;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= FULL;
            coef   <= UNITY;
        end else begin
            if (code_ld) code_q <= code_in;
            if (stb)     coef   <= slew.next;
        end
    end

    p_step_bound_r4: assert property (@(posedge clk) disable iff (rst)
        stb |=> (((coef >= $past(coef)) ? (coef - $past(coef)) : ($past(coef) - coef)) <= STEP_V));

    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(coef));

    p_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
        coef <= UNITY);

    p_mute_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (mute_req && stb && coef == '0) |=> coef == '0);

endmodule

// File: rtl/chan_gain.sv
module chan_gain
    import atten_ramp_pkg::*;
#(
    parameter int SW     = SMP_W,
    parameter int FRAC_W = GAIN_FRAC_W,
    parameter int ZLOG   = ZRUN_LOG2,
    localparam int COEF_W = FRAC_W + 1,
    localparam int PW     = SW + COEF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [SW-1:0]     smp_in,
    input  logic [COEF_W-1:0] coef,
    output logic [SW-1:0]     smp_out,
    output logic              mute
);

    localparam logic [PW-1:0]     BIAS  = (PW'(1) << FRAC_W) - PW'(1);
    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] biased;
    logic signed [PW-1:0] scaled;
    logic [ZLOG:0]        zrun_q;

    always_comb begin
        prod   = $signed({{(PW-SW){smp_in[SW-1]}}, smp_in})
               * $signed({{(PW-COEF_W){1'b0}}, coef});
        biased = prod + (prod[PW-1] ? $signed(BIAS) : $signed(PW'(0)));
        scaled = biased >>> FRAC_W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_out <= '0;
            zrun_q  <= '0;
        end else if (stb) begin
            smp_out <= scaled[SW-1:0];
            if (smp_in != '0)   zrun_q <= '0;
            else if (!zrun_q[ZLOG]) zrun_q <= zrun_q + 1'b1;
        end
    end

    assign mute = zrun_q[ZLOG] || (coef == '0);

    p_zero_gain_r2: assert property (@(posedge clk) disable iff (rst)
        (stb && coef == '0) |=> smp_out == '0);

    p_unity_pass_r1: assert property (@(posedge clk) disable iff (rst)
        (stb && coef == UNITY) |=> smp_out == $past(smp_in));

    p_run_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (stb && smp_in != '0) |=> mute == (coef == '0));

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> smp_out == '0);

endmodule

// File: rtl/atten_ramp.sv
module atten_ramp
    import atten_ramp_pkg::*;
#(
    parameter int SW     = SMP_W,
    parameter int CODE_W = ATT_CODE_W,
    parameter int FRAC_W = GAIN_FRAC_W,
    parameter int STEP   = RAMP_STEP,
    parameter int ZLOG   = ZRUN_LOG2,
    localparam int COEF_W = FRAC_W + 1,
    localparam int NCH    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [SW-1:0]     in_l,
    input  logic [SW-1:0]     in_r,
    input  logic [CODE_W-1:0] att_code,
    input  logic              att_load,
    input  logic              mute_req,
    output logic [SW-1:0]     out_l,
    output logic [SW-1:0]     out_r,
    output logic              mute_l,
    output logic              mute_r
);

    logic [COEF_W-1:0]         coef;
    logic [NCH-1:0][SW-1:0]    ch_in;
    logic [NCH-1:0][SW-1:0]    ch_out;
    logic [NCH-1:0]            ch_mute;

    assign ch_in[0] = in_l;
    assign ch_in[1] = in_r;

    gain_slew #(
        .CODE_W (CODE_W),
        .FRAC_W (FRAC_W),
        .STEP   (STEP)
    ) u_slew (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .code_in  (att_code),
        .code_ld  (att_load),
        .mute_req (mute_req),
        .coef     (coef)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_gain #(
            .SW     (SW),
            .FRAC_W (FRAC_W),
            .ZLOG   (ZLOG)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .stb     (smp_stb),
            .smp_in  (ch_in[c]),
            .coef    (coef),
            .smp_out (ch_out[c]),
            .mute    (ch_mute[c])
        );
    end

    assign out_l  = ch_out[0];
    assign out_r  = ch_out[1];
    assign mute_l = ch_mute[0];
    assign mute_r = ch_mute[1];

endmodule

// File: tb/test_atten_ramp.sv
`timescale 1ns/1ps
module test_atten_ramp;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_stb = 1'b0;
    logic [15:0]       in_l = '0, in_r = '0;
    logic [6:0]        att_code = '0;
    logic              att_load = 1'b0;
    logic              mute_req = 1'b0;
    logic [15:0]       out_l, out_r;
    logic              mute_l, mute_r;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    longint m_coef = 65536;
    int     m_code = 127;
    bit     m_mute = 0;
    int     m_zl = 0, m_zr = 0;

    atten_ramp i_atten_ramp (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .in_l(in_l), .in_r(in_r),
        .att_code(att_code), .att_load(att_load), .mute_req(mute_req),
        .out_l(out_l), .out_r(out_r), .mute_l(mute_l), .mute_r(mute_r)
    );

    always #4 clk = ~clk;

    function automatic longint gain_of(input int code);
        return (code == 127) ? 65536 : longint'(code) * 512;
    endfunction

    function automatic longint scale(input longint s, input longint c);
        longint p = s * c;
        if (p < 0) return -((-p) / 65536);
        return p / 65536;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model_step();
        longint g = m_mute ? 0 : gain_of(m_code);
        if (g > m_coef)      m_coef = (g - m_coef > 64) ? m_coef + 64 : g;
        else if (g < m_coef) m_coef = (m_coef - g > 64) ? m_coef - 64 : g;
    endfunction

    // one strobe; outputs (R10) and flags (R7 / R8) compared against the model
    task automatic strobe(input int l, input int r, input string tag, input bit with_load = 0, input int code = 0);
        @(negedge clk);
        in_l = 16'(l); in_r = 16'(r); smp_stb = 1'b1;
        if (with_load) begin att_code = 7'(code); att_load = 1'b1; end
        @(negedge clk);
        smp_stb = 1'b0; att_load = 1'b0;
        chk({tag, " R10 out_l"}, longint'($signed(out_l)), scale(l, m_coef));
        chk({tag, " R10 out_r"}, longint'($signed(out_r)), scale(r, m_coef));
        m_zl = (l != 0) ? 0 : ((m_zl < 8192) ? m_zl + 1 : 8192);
        m_zr = (r != 0) ? 0 : ((m_zr < 8192) ? m_zr + 1 : 8192);
        model_step();
        if (with_load) m_code = code;
        chk((m_coef == 0) ? {tag, " R7 mute_l"} : {tag, " R8 mute_l"},
            longint'(mute_l), longint'(m_coef == 0 || m_zl >= 8192));
        chk((m_coef == 0) ? {tag, " R7 mute_r"} : {tag, " R8 mute_r"},
            longint'(mute_r), longint'(m_coef == 0 || m_zr >= 8192));
    endtask

    task automatic load(input int code);
        @(negedge clk);
        att_code = 7'(code); att_load = 1'b1;
        @(negedge clk);
        att_load = 1'b0;
        m_code = code;
    endtask

    initial begin : wdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        // R9: reset holds outputs at zero even with strobes
        repeat (3) @(negedge clk);
        in_l = 16'd1234; in_r = -16'sd1234; smp_stb = 1'b1;
        @(negedge clk); @(negedge clk);
        smp_stb = 1'b0;
        chk("R9 out_l in reset", longint'(out_l), 0);
        chk("R9 out_r in reset", longint'(out_r), 0);
        chk("R9 mute_l after reset", longint'(mute_l), 0);
        chk("R9 mute_r after reset", longint'(mute_r), 0);
        rst = 1'b0;

        // R1: unity pass-through across the sample range
        for (int k = -32768; k < 32768; k += 257) strobe(k, -k - 1, "R1 unity");
        strobe(32767, -32768, "R1 extremes");

        // R4 / R2 / R7: full swing down in exactly 1024 strobes
        load(0);
        for (int k = 0; k < 1023; k++) strobe(-32768, 1000 + k, "R4 ramp down");
        chk("R4 not silent after 1023", longint'(mute_l), 0);
        strobe(-32768, 777, "R4 last step");
        chk("R7 silent after 1024", longint'(mute_l), 1);
        for (int k = 0; k < 8; k++) strobe(32767 - k, -32768 + k, "R2 zero gain");

        // R4: no movement without strobes
        repeat (20) @(negedge clk);
        strobe(-32768, 5, "R4 idle hold");

        // R3: every nonzero code, ascending
        for (int n = 1; n < 128; n++) begin
            load(n);
            for (int k = 0; k < 20; k++) strobe(-32768, (n * 251 + k * 1601) % 65536 - 32768, "R3 code sweep");
            strobe(32767, -32767, "R3 rounding");
            strobe(-1, 1, "R3 tiny");
        end

        // R5: retarget mid-ramp, in both directions
        load(0);
        for (int k = 0; k < 300; k++) strobe(-32768, 31000, "R5 down");
        load(64);
        for (int k = 0; k < 300; k++) strobe(-32768, -31000, "R5 retarget");
        load(127);
        for (int k = 0; k < 100; k++) strobe(-32768, 12345, "R5 reverse");
        // R5: load coinciding with a strobe uses the old code for that step
        strobe(-32768, 9, "R5 coincident load", 1, 10);
        for (int k = 0; k < 1100; k++) strobe(-32768, 4321, "R5 after coincident");

        // R6: soft mute, release mid-ramp, then full release
        load(127);
        for (int k = 0; k < 1100; k++) strobe(-32768, 222, "R5 settle");
        @(negedge clk); mute_req = 1'b1; m_mute = 1;
        for (int k = 0; k < 400; k++) strobe(-32768, -222, "R6 mute partial");
        @(negedge clk); mute_req = 1'b0; m_mute = 0;
        for (int k = 0; k < 100; k++) strobe(-32768, 333, "R6 release early");
        @(negedge clk); mute_req = 1'b1; m_mute = 1;
        for (int k = 0; k < 1100; k++) strobe(-32768, -333, "R6 mute full");
        load(50);
        for (int k = 0; k < 10; k++) strobe(-32768, 444, "R6 load while muted");
        @(negedge clk); mute_req = 1'b0; m_mute = 0;
        for (int k = 0; k < 500; k++) strobe(-32768, 555, "R6 release");

        // R8: zero run on the right channel only
        load(127);
        for (int k = 0; k < 1100; k++) strobe(-32768, 1, "R8 settle");
        for (int k = 0; k < 8191; k++) strobe(-32768, 0, "R8 run");
        chk("R8 mute_r below threshold", longint'(mute_r), 0);
        strobe(-32768, 0, "R8 threshold");
        chk("R8 mute_r at threshold", longint'(mute_r), 1);
        chk("R8 mute_l independent", longint'(mute_l), 0);
        for (int k = 0; k < 5; k++) strobe(-32768, 0, "R8 saturated");
        strobe(-32768, 7, "R8 clear");
        chk("R8 mute_r cleared", longint'(mute_r), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule